// File: doc/BRIEF.md
# Four-Channel Stereo Panning Mixer

The mixer takes the 4-bit amplitudes of four sound channels and combines them into one left and one right sample word. A panning byte decides, for each channel separately, whether it feeds the right side, the left side, both sides or neither. A master volume byte gives each side its own 3-bit level, and that side's sum is multiplied by the level plus one. Each channel also has a DAC-enable flag. A channel whose flag is low is silent, just as if its amplitude were zero.

The block is purely a datapath. Both sample words are registered, update on every clock edge from the inputs present at that edge, and clear to zero under a synchronous reset. Nothing is held between cycles, so a routing change takes effect on the very next sample. The master volume byte has two external-input enable bits, and this block does not use them.

Top module: `stmix_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `left_out` and `right_out` become 0 after that edge.
- R2: One clock edge after the inputs are presented, `right_out` equals (`vol_ctrl[2:0]` + 1) times the sum of `ch_amp` over every channel i where `pan_ctrl[i]` is 1 and `dac_on[i]` is 1. Channel i occupies `ch_amp[4*i+3:4*i]`.
- R3: One clock edge after the inputs are presented, `left_out` equals (`vol_ctrl[6:4]` + 1) times the sum of `ch_amp` over every channel i where `pan_ctrl[i+4]` is 1 and `dac_on[i]` is 1.
- R4: A channel whose two routing bits are both set adds its amplitude to both sides, and each side scales it by that side's own level.
- R5: A channel whose `dac_on` bit is 0 adds nothing to either side, whatever its amplitude and routing.
- R6: `vol_ctrl[7]` and `vol_ctrl[3]` have no effect on either output.
- R7: A channel whose routing bit for a side is cleared has its contribution removed from that side on the next clock edge. Nothing of its previous value remains.
- R8: With all four channels at amplitude 15, routed to both sides and at level 7, both outputs equal 480, the full scale of the 9-bit outputs, with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pan_ctrl | input | 8 | Routing: bit i sends channel i to the right, bit i+4 sends it to the left |
| vol_ctrl | input | 8 | Levels: bits 6:4 left, bits 2:0 right; bits 7 and 3 unused |
| ch_amp | input | 16 | Four 4-bit channel amplitudes, channel i at bits 4*i+3:4*i |
| dac_on | input | 4 | Per-channel DAC enable, 1 = active |
| left_out | output | 9 | Registered left sample |
| right_out | output | 9 | Registered right sample |

## Verification
The hardest case to reach is a channel that changes routing while its amplitude stays put. Its stale contribution has to disappear from one side within one edge, while the other side keeps it. The bench holds the amplitudes steady and switches a single routing bit between consecutive cycles. It also runs random patterns that mix DAC-off channels with non-zero amplitudes and set the unused volume bits. A directed full-scale case covers the top of the output range.

// File: rtl/stmix_pkg.sv
package stmix_pkg;

   // width of an unsigned value able to hold 0..maxv
   function automatic int bits_for(input int maxv);
      int w;
      w = 1;
      while ((1 << w) <= maxv) w++;
      return w;
   endfunction

   function automatic int sum_width(input int nch, input int aw);
      return bits_for(nch * ((1 << aw) - 1));
   endfunction

   function automatic int out_width(input int nch, input int aw, input int lw);
      return bits_for(nch * ((1 << aw) - 1) * (1 << lw));
   endfunction

   typedef enum logic [0:0] {
      SCALE_MULT     = 1'b0,
      SCALE_SHIFTADD = 1'b1
   } scale_style_e;

endpackage

// File: rtl/stmix_gate.sv
module stmix_gate #(
   parameter int AMP_W = 4
) (
   input  logic [AMP_W-1:0] amp,
   input  logic             dac_en,
   input  logic             to_left,
   input  logic             to_right,
   output logic [AMP_W-1:0] amp_left,
   output logic [AMP_W-1:0] amp_right
);

   logic [AMP_W-1:0] live_amp;

   always_comb begin
      live_amp  = dac_en ? amp : '0;
      amp_left  = to_left  ? live_amp : '0;
      amp_right = to_right ? live_amp : '0;
   end

endmodule

// File: rtl/stmix_side.sv
module stmix_side
   import stmix_pkg::*;
#(
   parameter int           NUM_CH = 4,
   parameter int           AMP_W  = 4,
   parameter int           LVL_W  = 3,
   parameter scale_style_e STYLE  = SCALE_MULT,
   localparam int          SUM_W  = sum_width(NUM_CH, AMP_W),
   localparam int          OUT_W  = out_width(NUM_CH, AMP_W, LVL_W)
) (
   input  logic [NUM_CH*AMP_W-1:0] amps,
   input  logic [LVL_W-1:0]        level,
   output logic [OUT_W-1:0]        scaled
);

   localparam int FAC_W = LVL_W + 1;

   logic [SUM_W-1:0] sum;
   logic [FAC_W-1:0] factor;

   always_comb begin
      sum = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         sum = sum + SUM_W'(amps[c*AMP_W +: AMP_W]);
      end
      factor = {1'b0, level} + FAC_W'(1);
   end

   generate
      if (STYLE == SCALE_MULT) begin : g_mult
         always_comb begin
            scaled = OUT_W'(sum) * OUT_W'(factor);
         end
      end else begin : g_shiftadd
         always_comb begin
            scaled = '0;
            for (int b = 0; b < FAC_W; b++) begin
               if (factor[b]) scaled = scaled + (OUT_W'(sum) << b);
            end
         end
      end
   endgenerate

   // R8: a level never shrinks the sum and never scales it past 2**LVL_W
   always_comb begin
      a_r8_scale_bounds: assert ((scaled >= OUT_W'(sum)) &&
                                 (scaled <= (OUT_W'(sum) << LVL_W)));
   end

endmodule

// File: rtl/stmix_top.sv
module stmix_top
   import stmix_pkg::*;
#(
   parameter int           NUM_CH    = 4,
   parameter int           AMP_W     = 4,
   parameter int           LVL_W     = 3,
   parameter int           VOL_W     = 8,
   parameter int           R_LVL_LSB = 0,
   parameter int           L_LVL_LSB = 4,
   parameter scale_style_e STYLE     = SCALE_MULT,
   localparam int          PAN_W     = 2 * NUM_CH,
   localparam int          OUT_W     = out_width(NUM_CH, AMP_W, LVL_W)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [PAN_W-1:0]        pan_ctrl,
   input  logic [VOL_W-1:0]        vol_ctrl,
   input  logic [NUM_CH*AMP_W-1:0] ch_amp,
   input  logic [NUM_CH-1:0]       dac_on,
   output logic [OUT_W-1:0]        left_out,
   output logic [OUT_W-1:0]        right_out
);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("stmix_top: NUM_CH must be at least 1");
      end
      if (AMP_W < 1 || LVL_W < 1) begin : g_bad_w
         $error("stmix_top: AMP_W and LVL_W must be at least 1");
      end
      if (R_LVL_LSB + LVL_W > VOL_W || L_LVL_LSB + LVL_W > VOL_W) begin : g_bad_fld
         $error("stmix_top: level field lies outside the volume byte");
      end
      if ((R_LVL_LSB < L_LVL_LSB) ? (R_LVL_LSB + LVL_W > L_LVL_LSB)
                                  : (L_LVL_LSB + LVL_W > R_LVL_LSB)) begin : g_bad_ovl
         $error("stmix_top: level fields overlap");
      end
   endgenerate

   logic [NUM_CH*AMP_W-1:0] amps_l, amps_r;
   logic [OUT_W-1:0]        mix_l, mix_r;
   logic [LVL_W-1:0]        lvl_l, lvl_r;
   logic                    unused_vol_bits;

   assign lvl_l = vol_ctrl[L_LVL_LSB +: LVL_W];
   assign lvl_r = vol_ctrl[R_LVL_LSB +: LVL_W];
   // external-input enable bits take no part in mixing
   assign unused_vol_bits = ^vol_ctrl;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
         stmix_gate #(.AMP_W(AMP_W)) u_gate (
            .amp       (ch_amp[gi*AMP_W +: AMP_W]),
            .dac_en    (dac_on[gi]),
            .to_left   (pan_ctrl[gi + NUM_CH]),
            .to_right  (pan_ctrl[gi]),
            .amp_left  (amps_l[gi*AMP_W +: AMP_W]),
            .amp_right (amps_r[gi*AMP_W +: AMP_W])
         );
      end
   endgenerate

   stmix_side #(
      .NUM_CH(NUM_CH), .AMP_W(AMP_W), .LVL_W(LVL_W), .STYLE(STYLE)
   ) u_side_l (
      .amps   (amps_l),
      .level  (lvl_l),
      .scaled (mix_l)
   );

   stmix_side #(
      .NUM_CH(NUM_CH), .AMP_W(AMP_W), .LVL_W(LVL_W), .STYLE(STYLE)
   ) u_side_r (
      .amps   (amps_r),
      .level  (lvl_r),
      .scaled (mix_r)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         left_out  <= '0;
         right_out <= '0;
      end else begin
         left_out  <= mix_l;
         right_out <= mix_r;
      end
   end

   // R1: reset clears both outputs on the next edge
   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (left_out == '0 && right_out == '0));

   // R2: nothing routed right gives a silent right side
   a_r2_right_unrouted: assert property (@(posedge clk) disable iff (rst)
      (pan_ctrl[NUM_CH-1:0] == '0) |=> (right_out == '0));

   // R3: nothing routed left gives a silent left side
   a_r3_left_unrouted: assert property (@(posedge clk) disable iff (rst)
      (pan_ctrl[PAN_W-1:NUM_CH] == '0) |=> (left_out == '0));

   // R5: all DACs off silences both sides
   a_r5_dac_silence: assert property (@(posedge clk) disable iff (rst)
      (dac_on == '0) |=> (left_out == '0 && right_out == '0));

   // R4: identical routing and level on both sides give identical outputs
   a_r4_symmetric: assert property (@(posedge clk) disable iff (rst)
      (pan_ctrl[NUM_CH-1:0] == pan_ctrl[PAN_W-1:NUM_CH] && lvl_l == lvl_r)
      |=> (left_out == right_out));

endmodule

// File: tb/sim_stmix_top.sv
module sim_stmix_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  pan_ctrl = '0;
   logic [7:0]  vol_ctrl = '0;
   logic [15:0] ch_amp = '0;
   logic [3:0]  dac_on = '0;
   logic [8:0]  left_out, right_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   stmix_top u0 (
      .clk(clk), .rst(rst), .pan_ctrl(pan_ctrl), .vol_ctrl(vol_ctrl),
      .ch_amp(ch_amp), .dac_on(dac_on), .left_out(left_out), .right_out(right_out)
   );

   function automatic int exp_side(input logic [7:0] pan, input logic [7:0] vol,
                                   input logic [15:0] amps, input logic [3:0] dac,
                                   input bit left);
      int s = 0;
      int lvl = left ? int'(vol[6:4]) : int'(vol[2:0]);
      for (int c = 0; c < 4; c++) begin
         if (dac[c] && (left ? pan[c+4] : pan[c])) s += int'(amps[c*4 +: 4]);
      end
      return s * (lvl + 1);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic apply(input logic [7:0] p, input logic [7:0] v,
                        input logic [15:0] a, input logic [3:0] d, input string req);
      @(negedge clk);
      pan_ctrl = p; vol_ctrl = v; ch_amp = a; dac_on = d;
      @(posedge clk);
      #1;
      check({req, " left"},  int'(left_out),  exp_side(p, v, a, d, 1'b1));
      check({req, " right"}, int'(right_out), exp_side(p, v, a, d, 1'b0));
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      // R1: drive non-zero inputs during reset
      pan_ctrl = 8'hFF; vol_ctrl = 8'h77; ch_amp = 16'hFFFF; dac_on = 4'hF;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset left",  int'(left_out),  0);
      check("R1 reset right", int'(right_out), 0);
      @(negedge clk); rst = 1'b0;

      // R2/R3: single-side routing
      apply(8'h0F, 8'h02, 16'h1234, 4'hF, "R2 right only");
      apply(8'hF0, 8'h50, 16'h1234, 4'hF, "R3 left only");
      apply(8'h21, 8'h31, 16'h00A5, 4'hF, "R2 R3 mixed");
      // R4: both sides, different levels
      apply(8'h44, 8'h70, 16'h0900, 4'hF, "R4 both sides");
      // R5: DAC off with non-zero amplitude
      apply(8'hFF, 8'h77, 16'hFFFF, 4'h0, "R5 all dac off");
      apply(8'hFF, 8'h33, 16'h8888, 4'h5, "R5 partial dac");
      // R6: unused bits set versus clear
      apply(8'hA5, 8'h88, 16'h4321, 4'hF, "R6 only unused bits");
      apply(8'hA5, 8'hBB, 16'h4321, 4'hF, "R6 unused plus levels");
      // R7: hold amps, drop one routing bit per cycle
      apply(8'hFF, 8'h11, 16'hCCCC, 4'hF, "R7 start");
      apply(8'hFE, 8'h11, 16'hCCCC, 4'hF, "R7 drop ch0 right");
      apply(8'h7E, 8'h11, 16'hCCCC, 4'hF, "R7 drop ch3 left");
      apply(8'h00, 8'h11, 16'hCCCC, 4'hF, "R7 drop all");
      // R8: full scale
      apply(8'hFF, 8'h77, 16'hFFFF, 4'hF, "R8 full scale");
      check("R8 full value", int'(left_out), 480);

      for (int n = 0; n < 300; n++) begin
         apply(8'($urandom), 8'($urandom), 16'($urandom), 4'($urandom),
               "R2 R3 R5 R6 random");
      end

      // R1: reset after activity
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      check("R1 late reset left",  int'(left_out),  0);
      check("R1 late reset right", int'(right_out), 0);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule